// File: doc/BRIEF.md
# Bit-Band Alias Bus Bridge

This bridge sits between a processor-side request port and a downstream memory or peripheral bus. Each bit of every word in a target window also has its own full-word address in a wider alias window. A single store to one of those alias addresses becomes a read-modify-write on the downstream bus. The bridge reads the target word, replaces the one named bit, and writes the word back. The lock output is held high across both cycles, so no other master can slip an access between them.

A read from an alias address performs one unlocked downstream read and returns the selected bit as 0 or 1. Any address outside the alias window is forwarded unchanged as a single read or write. The upstream ready output stays low until the whole downstream sequence has finished. It then pulses for one cycle to complete the request.

Top module: `bitband_bridge`

## Requirements
- R1: An access whose address lies outside the alias window produces exactly one downstream cycle of the same kind, with the same address and write data, and with lock low. A read returns the downstream word unchanged.
- R2: An alias address A maps to a target word address and a bit number. With offset = A - ALIAS_BASE, the word address is TARGET_BASE + (offset >> 7) * 4 and the bit number is (offset >> 2) & 31. The alias window spans 2^ALIAS_SPAN_LOG2 bytes starting at ALIAS_BASE.
- R3: An alias write produces exactly one downstream read followed by exactly one downstream write, and both use the same target word address.
- R4: An alias write changes only the addressed bit of the target word. Bit 0 of the upstream write data is the new value, and write-data bits 31 to 1 have no effect.
- R5: During an alias write, lock is high on the read cycle and on the write cycle, with no idle cycle between them. At all other times lock is low.
- R6: An alias read performs one downstream read with lock low. It returns the addressed bit in bit 0 of the read data, with bits 31 to 1 at zero.
- R7: Upstream ready is low while any downstream cycle is in progress. It is high for exactly one cycle per request, after the last downstream cycle has completed.
- R8: While reset is low, the read strobe, write strobe, lock and upstream ready are all low. A reset that arrives mid-sequence abandons the sequence, and no downstream write completes.
- R9: A downstream strobe, together with its address and write data, is held stable until the cycle in which downstream ready is high. The read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Upstream request present; held until up_ready |
| up_write | input | 1 | 1 = store, 0 = load |
| up_addr | input | 32 | Upstream byte address |
| up_wdata | input | 32 | Upstream store data |
| up_ready | output | 1 | One-cycle completion pulse |
| up_rdata | output | 32 | Load result, valid while up_ready is high |
| dn_rd | output | 1 | Downstream read strobe |
| dn_wr | output | 1 | Downstream write strobe |
| dn_lock | output | 1 | Bus lock across a read-modify-write pair |
| dn_addr | output | 32 | Downstream word address |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, sampled when dn_ready is high |
| dn_ready | input | 1 | Completes the current downstream cycle |

## Verification
The assertions assume that the upstream master keeps up_valid and its address and data steady until it sees up_ready, and then drops up_valid before the following clock edge. They also assume that dn_ready is only considered while a strobe is high. The bench drives each request at a falling edge and withdraws it just after the completing rising edge. Its downstream memory model raises ready only while a strobe is present, after a wait that varies from request to request, so the hold and stall properties are exercised with zero and non-zero waits.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int AW        = 32;
  localparam int DW        = 32;
  localparam int LANE_LOG2 = $clog2(DW / 8);
  localparam int BIT_W     = $clog2(DW);

  typedef logic [AW-1:0]    addr_t;
  typedef logic [DW-1:0]    data_t;
  typedef logic [BIT_W-1:0] bitsel_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_RESP} seq_st_t;

  typedef struct packed {
    logic    write;
    logic    alias_op;
    addr_t   addr;
    bitsel_t bitn;
    data_t   data;
  } bus_req_t;

  // Address falls inside [base, base + 2**span_log2)
  function automatic logic in_alias(addr_t a, addr_t base, int span_log2);
    addr_t off;
    off = a - base;
    return (a >= base) && ((off >> span_log2) == '0);
  endfunction

  // Each target word owns DW alias words: strip bit index and lane bits
  function automatic addr_t alias_word(addr_t a, addr_t alias_base, addr_t tgt_base);
    addr_t off;
    off = a - alias_base;
    return tgt_base + ((off >> (BIT_W + LANE_LOG2)) << LANE_LOG2);
  endfunction

  function automatic bitsel_t alias_bit(addr_t a, addr_t alias_base);
    addr_t off;
    off = a - alias_base;
    return off[BIT_W+LANE_LOG2-1:LANE_LOG2];
  endfunction
endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter addr_t ALIAS_BASE      = 32'h2200_0000,
  parameter addr_t TARGET_BASE     = 32'h2000_0000,
  parameter int    ALIAS_SPAN_LOG2 = 25
) (
  input  logic     up_write,
  input  addr_t    up_addr,
  input  data_t    up_wdata,
  output bus_req_t req
);
  logic hit;

  always_comb begin
    hit          = in_alias(up_addr, ALIAS_BASE, ALIAS_SPAN_LOG2);
    req.write    = up_write;
    req.alias_op = hit;
    req.addr     = hit ? alias_word(up_addr, ALIAS_BASE, TARGET_BASE) : up_addr;
    req.bitn     = hit ? alias_bit(up_addr, ALIAS_BASE) : '0;
    req.data     = up_wdata;
  end
endmodule

// File: rtl/bb_bitmerge.sv
module bb_bitmerge
  import bb_pkg::*;
(
  input  data_t   word,
  input  bitsel_t bitn,
  input  logic    val,
  output data_t   merged,
  output logic    picked
);
  for (genvar i = 0; i < DW; i++) begin : g_lane
    assign merged[i] = (bitn == BIT_W'(i)) ? val : word[i];
  end

  assign picked = word[bitn];
endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     up_valid,
  input  bus_req_t req_d,
  output logic     up_ready,
  output data_t    up_rdata,
  output logic     dn_rd,
  output logic     dn_wr,
  output logic     dn_lock,
  output addr_t    dn_addr,
  output data_t    dn_wdata,
  input  data_t    dn_rdata,
  input  logic     dn_ready,
  output bus_req_t req_q,
  output data_t    word_q,
  input  data_t    merged,
  input  logic     picked
);
  seq_st_t st_q;

  // Named internal events
  logic rd_done, wr_done, rmw_op, accept;
  assign rd_done = (st_q == ST_RD) && dn_ready;
  assign wr_done = (st_q == ST_WR) && dn_ready;
  assign rmw_op  = req_q.alias_op && req_q.write;
  assign accept  = (st_q == ST_IDLE) && up_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      req_q  <= '0;
      word_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          req_q <= req_d;
          st_q  <= (req_d.write && !req_d.alias_op) ? ST_WR : ST_RD;
        end
        ST_RD: if (rd_done) begin
          word_q <= dn_rdata;
          st_q   <= rmw_op ? ST_WR : ST_RESP;
        end
        ST_WR:   if (wr_done) st_q <= ST_RESP;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dn_rd    = (st_q == ST_RD);
    dn_wr    = (st_q == ST_WR);
    dn_lock  = rmw_op && (dn_rd || dn_wr);
    dn_addr  = req_q.addr;
    dn_wdata = req_q.alias_op ? merged : req_q.data;
    up_ready = (st_q == ST_RESP);
    up_rdata = '0;
    if (up_ready && !req_q.write)
      up_rdata = req_q.alias_op ? {{(DW-1){1'b0}}, picked} : word_q;
  end

  // Guards on the sequencer
  assert_lock_gapless_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_rd && dn_lock && dn_ready) |=> (dn_wr && dn_lock));
  assert_lock_in_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_lock |-> (dn_rd || dn_wr));
  assert_rmw_same_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_rd && dn_lock && dn_ready) |=> $stable(dn_addr));
  assert_one_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_wr && dn_lock) |-> ($countones(dn_wdata ^ word_q) <= 1));
  assert_wait_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((dn_rd || dn_wr) && !dn_ready) |=>
      ($stable(dn_addr) && $stable(dn_rd) && $stable(dn_wr) && $stable(dn_wdata)));
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(dn_rd && dn_wr));
  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_rd || dn_wr) |-> !up_ready);
  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |=> !up_ready);
  assert_unlocked_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_rd && dn_ready && !dn_lock) |=> up_ready);
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter addr_t ALIAS_BASE      = 32'h2200_0000,
  parameter addr_t TARGET_BASE     = 32'h2000_0000,
  parameter int    ALIAS_SPAN_LOG2 = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  input  logic          up_write,
  input  logic [AW-1:0] up_addr,
  input  logic [DW-1:0] up_wdata,
  output logic          up_ready,
  output logic [DW-1:0] up_rdata,
  output logic          dn_rd,
  output logic          dn_wr,
  output logic          dn_lock,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_wdata,
  input  logic [DW-1:0] dn_rdata,
  input  logic          dn_ready
);
  bus_req_t req_d, req_q;
  data_t    word_q, merged;
  logic     picked;

  bb_decode #(
    .ALIAS_BASE     (ALIAS_BASE),
    .TARGET_BASE    (TARGET_BASE),
    .ALIAS_SPAN_LOG2(ALIAS_SPAN_LOG2)
  ) decode_i (
    .up_write(up_write),
    .up_addr (up_addr),
    .up_wdata(up_wdata),
    .req     (req_d)
  );

  bb_bitmerge merge_i (
    .word  (word_q),
    .bitn  (req_q.bitn),
    .val   (req_q.data[0]),
    .merged(merged),
    .picked(picked)
  );

  bb_seq seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_valid(up_valid),
    .req_d   (req_d),
    .up_ready(up_ready),
    .up_rdata(up_rdata),
    .dn_rd   (dn_rd),
    .dn_wr   (dn_wr),
    .dn_lock (dn_lock),
    .dn_addr (dn_addr),
    .dn_wdata(dn_wdata),
    .dn_rdata(dn_rdata),
    .dn_ready(dn_ready),
    .req_q   (req_q),
    .word_q  (word_q),
    .merged  (merged),
    .picked  (picked)
  );

  // Outside the alias window the forwarded write carries the upstream data untouched
  assert_pass_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_wr && !req_q.alias_op) |-> (dn_wdata == req_q.data && !dn_lock));
endmodule

// File: tb/bitband_bridge_tb_top.sv
`timescale 1ns/1ps
module bitband_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_valid = 1'b0, up_write = 1'b0;
  logic [31:0] up_addr = '0, up_wdata = '0;
  logic        up_ready;
  logic [31:0] up_rdata;
  logic        dn_rd, dn_wr, dn_lock;
  logic [31:0] dn_addr, dn_wdata, dn_rdata;
  logic        dn_ready = 1'b0;

  always #2.5 clk = ~clk;

  bitband_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_write(up_write), .up_addr(up_addr), .up_wdata(up_wdata),
    .up_ready(up_ready), .up_rdata(up_rdata),
    .dn_rd(dn_rd), .dn_wr(dn_wr), .dn_lock(dn_lock), .dn_addr(dn_addr),
    .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_ready(dn_ready)
  );

  // Downstream memory model, indexed by address bits 9:2
  logic [31:0] mem [256];
  assign dn_rdata = mem[dn_addr[9:2]];

  int dly = 0, wait_cnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_ready <= 1'b0; wait_cnt <= 0;
    end else if ((dn_rd || dn_wr) && !dn_ready) begin
      if (wait_cnt >= dly) begin dn_ready <= 1'b1; wait_cnt <= 0; end
      else wait_cnt <= wait_cnt + 1;
    end else dn_ready <= 1'b0;
  end

  // Per-request observation of the downstream side
  int n_rd, n_wr, n_rdy;
  logic lk_hi, lk_lo, hold_bad, prev_wait;
  logic [31:0] rd_a, wr_a, prev_addr;
  always @(posedge clk) begin
    if (rst_n) begin
      if (dn_rd || dn_wr) begin
        if (dn_lock) lk_hi = 1'b1; else lk_lo = 1'b1;
      end
      if (dn_rd && dn_ready) begin n_rd++; rd_a = dn_addr; end
      if (dn_wr && dn_ready) begin n_wr++; wr_a = dn_addr; mem[dn_addr[9:2]] = dn_wdata; end
      if (up_ready) n_rdy++;
      if (prev_wait && dn_addr != prev_addr) hold_bad = 1'b1;
      prev_wait = (dn_rd || dn_wr) && !dn_ready;
      prev_addr = dn_addr;
    end
  end

  int n_checks = 0, n_err = 0;
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic wr, input logic [31:0] a, input logic [31:0] d,
                       input int dl, output logic [31:0] rd);
    int guard = 0;
    @(negedge clk);
    dly = dl; n_rd = 0; n_wr = 0; n_rdy = 0;
    lk_hi = 1'b0; lk_lo = 1'b0; hold_bad = 1'b0; prev_wait = 1'b0;
    rd_a = 'x; wr_a = 'x;
    up_valid = 1'b1; up_write = wr; up_addr = a; up_wdata = d;
    do begin @(negedge clk); guard++; end while (!up_ready && guard < 200);
    if (!up_ready) begin
      n_checks++; n_err++;
      $display("FAIL R7: ready actual 0 after %0d cycles expected 1", guard);
    end
    rd = up_rdata;
    @(posedge clk);
    #1 up_valid = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] chk;   // expected downstream word address
    logic [31:0] exp;   // read result, or memory word after a write
    logic [1:0]  nrd;
    logic [1:0]  nwr;
    logic        lk;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 32'h2000_0008, 32'h1234_5678, 32'h2000_0008, 32'h1234_5678, 2'd0, 2'd1, 1'b0},
    '{1'b0, 32'h2000_0008, 32'h0,         32'h2000_0008, 32'h1234_5678, 2'd1, 2'd0, 1'b0},
    '{1'b1, 32'h2200_0000, 32'h0000_0001, 32'h2000_0000, 32'h0000_0001, 2'd1, 2'd1, 1'b1},
    '{1'b1, 32'h2200_007C, 32'hFFFF_FFFF, 32'h2000_0000, 32'h8000_0001, 2'd1, 2'd1, 1'b1},
    '{1'b1, 32'h2200_0090, 32'hFFFF_FFFE, 32'h2000_0004, 32'h0000_00E0, 2'd1, 2'd1, 1'b1},
    '{1'b1, 32'h2200_0280, 32'h0000_0002, 32'h2000_0014, 32'hFFFF_FFFE, 2'd1, 2'd1, 1'b1},
    '{1'b0, 32'h2200_007C, 32'h0,         32'h2000_0000, 32'h0000_0001, 2'd1, 2'd0, 1'b0},
    '{1'b0, 32'h2200_0090, 32'h0,         32'h2000_0004, 32'h0000_0000, 2'd1, 2'd0, 1'b0},
    '{1'b0, 32'h2200_009C, 32'h0,         32'h2000_0004, 32'h0000_0001, 2'd1, 2'd0, 1'b0},
    '{1'b1, 32'h2200_0000, 32'h0000_0001, 32'h2000_0000, 32'h8000_0001, 2'd1, 2'd1, 1'b1},
    '{1'b1, 32'h2400_0100, 32'hCAFE_F00D, 32'h2400_0100, 32'hCAFE_F00D, 2'd0, 2'd1, 1'b0},
    '{1'b1, 32'h2200_640C, 32'h0000_0001, 32'h2000_0320, 32'h0000_0008, 2'd1, 2'd1, 1'b1},
    '{1'b1, 32'h21FF_FFFC, 32'h0BAD_BEEF, 32'h21FF_FFFC, 32'h0BAD_BEEF, 2'd0, 2'd1, 1'b0},
    '{1'b0, 32'h2400_0100, 32'h0,         32'h2400_0100, 32'hCAFE_F00D, 2'd1, 2'd0, 1'b0},
    '{1'b0, 32'h2200_6400, 32'h0,         32'h2000_0320, 32'h0000_0000, 2'd1, 2'd0, 1'b0},
    '{1'b0, 32'h2200_02FC, 32'h0,         32'h2000_0014, 32'h0000_0001, 2'd1, 2'd0, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic alias_hit;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[1] = 32'h0000_00F0;
    mem[5] = 32'hFFFF_FFFF;

    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 reset outputs", {28'h0, up_ready, dn_rd, dn_wr, dn_lock}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle after reset", {28'h0, up_ready, dn_rd, dn_wr, dn_lock}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      alias_hit = (TBL[i].addr >= 32'h2200_0000) && (TBL[i].addr < 32'h2400_0000);
      do_op(TBL[i].wr, TBL[i].addr, TBL[i].wdata, i % 3, rd);
      if (TBL[i].wr)
        check(alias_hit ? "R4 word after write" : "R1 word after write", mem[TBL[i].chk[9:2]], TBL[i].exp);
      else
        check(alias_hit ? "R6 read result" : "R1 read result", rd, TBL[i].exp);
      check("R3 downstream read count", n_rd, {30'h0, TBL[i].nrd});
      check("R3 downstream write count", n_wr, {30'h0, TBL[i].nwr});
      if (TBL[i].nrd != 0) check("R2 read address", rd_a, TBL[i].chk);
      if (TBL[i].nwr != 0) check("R2 write address", wr_a, TBL[i].chk);
      check("R5 lock on every strobe", {31'h0, lk_hi}, {31'h0, TBL[i].lk});
      check("R5 no unlocked strobe", {31'h0, lk_lo}, {31'h0, ~TBL[i].lk});
      check("R7 ready pulses", n_rdy, 1);
      check("R9 address held while waiting", {31'h0, hold_bad}, 32'h0);
    end

    // R4: neighbouring words untouched by the alias writes
    check("R4 neighbour word 3", mem[3], 32'h0);
    check("R4 neighbour word 6", mem[6], 32'h0);

    // R7 / R9: long downstream wait on a locked pair
    do_op(1'b1, 32'h2200_0284, 32'h0, 7, rd);
    check("R4 long-wait clear bit 1", mem[5], 32'hFFFF_FFFC);
    check("R7 single ready after long wait", n_rdy, 1);
    check("R9 hold during long wait", {31'h0, hold_bad}, 32'h0);

    // R8: reset in the middle of a locked write cycle
    @(negedge clk);
    dly = 8;
    up_valid = 1'b1; up_write = 1'b1; up_addr = 32'h2200_0180; up_wdata = 32'h1;
    for (int g = 0; g < 50 && !dn_wr; g++) @(negedge clk);
    check("R5 lock during write before reset", {31'h0, dn_lock}, 32'h1);
    rst_n = 1'b0; up_valid = 1'b0;
    #1;
    check("R8 outputs low in mid-sequence reset", {28'h0, up_ready, dn_rd, dn_wr, dn_lock}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 abandoned write left word 3", mem[3], 32'h0);
    check("R8 idle after mid-sequence reset", {28'h0, up_ready, dn_rd, dn_wr, dn_lock}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule